// File: doc/BRIEF.md
# System Clock Ratio Detector and Word-Clock Sync Monitor

This block runs entirely on the system clock of an audio converter. It measures the word-clock period in system clock cycles and works out whether the system clock runs at 256, 384 or 512 times the sample rate. From that result it produces a clock enable that fires 256 times per sample period, so the downstream filter timing is the same whatever ratio is in use.

The block also tracks the phase of the word clock against the system clock from one frame to the next. The word clock may have any phase relative to the system clock, but that relationship must stay fixed. Each frame's deviation from the nominal period is added to a drift total. When the total grows past six bit-clock periods, the block declares loss of synchronization and stops the enable. Lock returns once two consecutive frames measure the same valid period. The enable is meant to feed a decimation filter. A sync-lost flag is meant to feed a muting stage.

Top module: `clk_ratio_sync_mon`

## Requirements
- R1: The period is the number of system clock cycles between consecutive word-clock rising edges, and it is evaluated at each rising edge. A period within ±2 cycles of 256, 384 or 512 sets ratio_valid and ratio_code to 1, 2 or 3. Any other period clears ratio_valid and sets ratio_code to 0. The first rising edge after reset only starts the measurement.
- R2: During and right after reset, ratio_valid=0, ratio_code=0, sync_lost=1, sync_ok=0 and en256=0.
- R3: If no word-clock rising edge arrives for more than 514 cycles, ratio_valid is cleared, ratio_code goes to 0 and sync_lost is set, all before the next edge.
- R4: While sync is lost, sync_ok is set at an edge whose period is valid and equal to the period measured at the previous edge. The drift total is then cleared. sync_ok is only ever high together with ratio_valid.
- R5: While locked, an edge whose period is invalid or falls into a different ratio class than the locked one sets sync_lost at that edge.
- R6: While locked, every edge adds (period − nominal) to the drift total. The block stays locked while the magnitude of the total is at most 6 bit clocks, where one bit clock is nominal/64 cycles (limits of 24, 36 and 48). A larger total sets sync_lost.
- R7: At ratio_code=1 with sync_ok, en256 is high on every cycle.
- R8: At ratio_code=2 with sync_ok, en256 is high on two cycles out of every three, and the pattern restarts at each word-clock edge. A 384-cycle frame gives exactly 256 enables.
- R9: At ratio_code=3 with sync_ok, en256 is high on every other cycle, starting at the edge cycle. A 512-cycle frame gives exactly 256 enables.
- R10: en256 stays low whenever sync_lost is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_clk | input | 1 | Word clock, synchronous to clk |
| ratio_valid | output | 1 | A supported ratio is detected |
| ratio_code | output | 2 | 0 none, 1 = 256x, 2 = 384x, 3 = 512x |
| en256 | output | 1 | Clock enable at 256 times the sample rate |
| sync_lost | output | 1 | Synchronization lost |
| sync_ok | output | 1 | Synchronization held |

## Verification
The assertions check a set of properties on every cycle. The enable never fires while sync is lost. It is continuous at the 256 ratio. Lock always comes with a valid ratio, and a cleared ratio always reads code 0. A rise of ratio_valid or sync_ok only follows a cycle with the word clock high. The bench is needed for the behaviours that span whole frames. These are the enable counts per frame at 384 and 512, the drift total crossing its scaled limit, relock after two equal periods, and the timeout on a stopped word clock. It checks them against a frame-level model fed with random jitter and ratio changes.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam logic [1:0] RC_NONE = 2'd0;
  localparam logic [1:0] RC_256  = 2'd1;
  localparam logic [1:0] RC_384  = 2'd2;
  localparam logic [1:0] RC_512  = 2'd3;

  typedef enum logic {ST_LOST = 1'b0, ST_LOCK = 1'b1} sync_e;

  // nominal frame length in system clocks for a ratio code
  function automatic int nom_of(logic [1:0] code, int base);
    return (int'(code) + 1) * base / 2;
  endfunction
endpackage

// File: rtl/crs_classify.sv
module crs_classify #(
  parameter int BASE = 256,
  parameter int TOL  = 2,
  parameter int CW   = 10
) (
  input  logic [CW-1:0] period,
  output logic [1:0]    cls
);
  logic [3:1] hit;

  for (genvar k = 1; k <= 3; k++) begin : g_win
    localparam int NOM = (k + 1) * BASE / 2;
    assign hit[k] = (int'(period) >= NOM - TOL) && (int'(period) <= NOM + TOL);
  end

  always_comb begin
    cls = 2'd0;
    for (int k = 1; k <= 3; k++) begin
      if (hit[k]) cls = 2'(k);
    end
  end
endmodule

// File: rtl/crs_sync.sv
module crs_sync
  import crs_pkg::*;
#(
  parameter int BASE    = 256,
  parameter int BC_DIV  = 64,
  parameter int LOSS_BC = 6,
  parameter int CW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_ev,
  input  logic          primed,
  input  logic          timeout,
  input  logic [CW-1:0] period,
  input  logic [1:0]    cls,
  output logic          valid,
  output logic [1:0]    code,
  output logic          locked
);
  sync_e               state_q, state_n;
  logic [1:0]          code_q, code_n;
  logic                valid_q, valid_n;
  logic [CW-1:0]       last_q, last_n;
  logic signed [CW:0]  acc_q, acc_n;
  int                  nom, lim, acc_t;

  always_comb begin
    state_n = state_q;
    code_n  = code_q;
    valid_n = valid_q;
    last_n  = last_q;
    acc_n   = acc_q;
    nom     = nom_of(code_q, BASE);
    lim     = LOSS_BC * nom / BC_DIV;
    acc_t   = int'(acc_q) + int'(period) - nom;
    if (edge_ev && primed) begin
      last_n  = period;
      valid_n = (cls != RC_NONE);
      code_n  = cls;
      if (state_q == ST_LOCK) begin
        if (cls == RC_NONE || cls != code_q) begin
          state_n = ST_LOST;
        end else if (acc_t > lim || acc_t < -lim) begin
          state_n = ST_LOST;
        end else begin
          acc_n = acc_t[CW:0];
        end
      end else if (cls != RC_NONE && period == last_q) begin
        state_n = ST_LOCK;
        acc_n   = '0;
      end
    end else if (timeout) begin
      valid_n = 1'b0;
      code_n  = RC_NONE;
      state_n = ST_LOST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOST;
      code_q  <= RC_NONE;
      valid_q <= 1'b0;
      last_q  <= '0;
      acc_q   <= '0;
    end else begin
      state_q <= state_n;
      code_q  <= code_n;
      valid_q <= valid_n;
      last_q  <= last_n;
      acc_q   <= acc_n;
    end
  end

  assign valid  = valid_q;
  assign code   = code_q;
  assign locked = (state_q == ST_LOCK);
endmodule

// File: rtl/crs_enable.sv
module crs_enable
  import crs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       edge_ev,
  input  logic [1:0] code,
  input  logic       locked,
  output logic       en
);
  logic [1:0] ph_q, ph_n;
  logic [1:0] wrap;

  assign wrap = (code == RC_384) ? 2'd2 : 2'd1;

  always_comb begin
    if (edge_ev)           ph_n = 2'd0;
    else if (ph_q >= wrap) ph_n = 2'd0;
    else                   ph_n = ph_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 2'd0;
    else        ph_q <= ph_n;
  end

  always_comb begin
    unique case (code)
      RC_256:  en = locked;
      RC_384:  en = locked && (ph_q != 2'd2);
      RC_512:  en = locked && (ph_q == 2'd0);
      default: en = 1'b0;
    endcase
  end
endmodule

// File: rtl/clk_ratio_sync_mon.sv
module clk_ratio_sync_mon
  import crs_pkg::*;
#(
  parameter int BASE    = 256,
  parameter int TOL     = 2,
  parameter int BC_DIV  = 64,
  parameter int LOSS_BC = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_clk,
  output logic       ratio_valid,
  output logic [1:0] ratio_code,
  output logic       en256,
  output logic       sync_lost,
  output logic       sync_ok
);
  localparam int MAXP = 2 * BASE + TOL;
  localparam int CW   = $clog2(MAXP + 2);
  localparam logic [CW-1:0] PSAT = CW'(MAXP + 1);

  logic          wc_q, primed_q, primed_n;
  logic [CW-1:0] per_q, per_n;
  logic          edge_ev, timeout, locked;
  logic [1:0]    cls;

  assign edge_ev = word_clk & ~wc_q;
  assign timeout = !edge_ev && (per_q == PSAT);

  always_comb begin
    primed_n = primed_q | edge_ev;
    if (edge_ev)             per_n = CW'(1);
    else if (per_q == PSAT)  per_n = per_q;
    else                     per_n = per_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q     <= 1'b0;
      primed_q <= 1'b0;
      per_q    <= '0;
    end else begin
      wc_q     <= word_clk;
      primed_q <= primed_n;
      per_q    <= per_n;
    end
  end

  crs_classify #(.BASE(BASE), .TOL(TOL), .CW(CW)) u_cls (
    .period (per_q),
    .cls    (cls)
  );

  crs_sync #(.BASE(BASE), .BC_DIV(BC_DIV), .LOSS_BC(LOSS_BC), .CW(CW)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .edge_ev (edge_ev),
    .primed  (primed_q),
    .timeout (timeout),
    .period  (per_q),
    .cls     (cls),
    .valid   (ratio_valid),
    .code    (ratio_code),
    .locked  (locked)
  );

  crs_enable u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .edge_ev (edge_ev),
    .code    (ratio_code),
    .locked  (locked),
    .en      (en256)
  );

  assign sync_ok   = locked;
  assign sync_lost = ~locked;
endmodule

// File: rtl/crs_checker.sv
module crs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       word_clk,
  input logic       ratio_valid,
  input logic [1:0] ratio_code,
  input logic       en256,
  input logic       sync_lost,
  input logic       sync_ok
);
  AST_LOCK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ok |-> ratio_valid); // R4
  AST_EN_OFF_WHEN_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> !en256); // R10
  AST_EN_FULL_AT_256: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && ratio_code == 2'd1) |-> en256); // R7
  AST_VALID_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_valid) |-> $past(word_clk)); // R1
  AST_LOCK_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> $past(word_clk)); // R4
  AST_NO_CODE_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_valid |-> (ratio_code == 2'd0)); // R3
endmodule

bind clk_ratio_sync_mon crs_checker u_chk (.*);

// File: tb/clk_ratio_sync_mon_test.sv
module clk_ratio_sync_mon_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       word_clk = 1'b0;
  logic       ratio_valid, en256, sync_lost, sync_ok;
  logic [1:0] ratio_code;

  int errs = 0, checks = 0;
  bit done = 0;

  // frame-level model
  bit m_primed = 0, m_valid = 0, m_lock = 0;
  int m_code = 0, m_acc = 0, m_last = 0, prev_len = 0;

  clk_ratio_sync_mon uut (.*);

  always #10 clk = ~clk;

  function automatic int f_nom(int c);
    return (c + 1) * 128;
  endfunction

  function automatic int f_cls(int p);
    for (int c = 1; c <= 3; c++)
      if (p >= f_nom(c) - 2 && p <= f_nom(c) + 2) return c;
    return 0;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(int p);
    int pc, cls, t, lim;
    if (!m_primed) begin m_primed = 1; return; end
    pc  = (p > 515) ? 515 : p;
    cls = f_cls(pc);
    if (m_lock) begin
      t   = m_acc + pc - f_nom(m_code);
      lim = 6 * f_nom(m_code) / 64;
      if (cls == 0 || cls != m_code) m_lock = 0;
      else if (t > lim || t < -lim)  m_lock = 0;
      else                           m_acc = t;
    end else if (cls != 0 && pc == m_last) begin
      m_lock = 1; m_acc = 0;
    end
    m_valid = (cls != 0);
    m_code  = cls;
    m_last  = pc;
  endtask

  task automatic send_frame(int p, string tag);
    int cnt = 0;
    model_edge(prev_len);
    prev_len = p;
    for (int i = 0; i < p; i++) begin
      word_clk = (i < p / 2);
      @(posedge clk);
      @(negedge clk);
      if (i == 0) begin
        check(ratio_valid == m_valid, "R1 valid", int'(ratio_valid), int'(m_valid));
        check(int'(ratio_code) == m_code, "R1 code", int'(ratio_code), m_code);
        check(sync_ok == m_lock && sync_lost == !m_lock, tag, int'(sync_ok), int'(m_lock));
      end
      cnt += int'(en256);
    end
    if (p > 514) begin
      m_valid = 0; m_code = 0; m_lock = 0;
      check(!ratio_valid && ratio_code == 2'd0, "R3 valid", int'(ratio_valid), 0);
      check(sync_lost, "R3 lost", int'(sync_lost), 1);
    end else if (!m_lock) begin
      check(cnt == 0, "R10 en count", cnt, 0);
    end else if (p == f_nom(m_code)) begin
      if (m_code == 1)      check(cnt == 256, "R7 en count", cnt, 256);
      else if (m_code == 2) check(cnt == 256, "R8 en count", cnt, 256);
      else                  check(cnt == 256, "R9 en count", cnt, 256);
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int nom, p;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!ratio_valid && ratio_code == 2'd0, "R2 ratio", int'(ratio_code), 0);
    check(sync_lost && !sync_ok && !en256, "R2 sync", int'(sync_ok), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sync_lost && !en256, "R2 after release", int'(sync_lost), 1);

    repeat (6) send_frame(256, "R4 lock 256");
    repeat (5) send_frame(384, "R5 switch 384");
    repeat (5) send_frame(512, "R5 switch 512");
    for (int i = 0; i < 8; i++) send_frame((i % 2) ? 514 : 510, "R6 jitter within");
    repeat (3) send_frame(256, "R4 relock");
    repeat (14) send_frame(258, "R6 drift loss");
    repeat (3) send_frame(256, "R4 relock");
    repeat (2) send_frame(300, "R1 invalid");
    repeat (3) send_frame(256, "R4 relock");
    send_frame(700, "R3 timeout");
    repeat (4) send_frame(384, "R4 relock");

    nom = 384;
    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(9) == 0) nom = f_nom(1 + $urandom_range(2));
      if ($urandom_range(1) == 0) p = nom;
      else                        p = nom + $urandom_range(4) - 2;
      send_frame(p, "R6 random");
    end
    send_frame(256, "R6 random");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule